// File: doc/BRIEF.md
# Interrupt Acceptance Mask with Nesting Stack

This block sits on the processor side of an interrupt system. An arbiter upstream offers at most one pending request per cycle, with a 3-bit priority level. The block keeps the current 3-bit mask level. It takes a request whose level reaches the mask. On taking it, the block raises the mask to one above the taken level, so only requests of higher priority can preempt the handler that now runs. The mask that was in force before is pushed onto a small internal last-in-first-out store. A return strobe pops that store and puts the saved mask back.

Level 7 is the non-maskable level. It is taken at any mask value, and the mask then stays at 7 instead of wrapping. The mask comes out of reset at 7, so every maskable level is blocked until software loads a lower value through the mask-write port. Each accepted request gives an accept pulse. A one-cycle acknowledge follows, which tells the arbiter to clear the flag of the source it granted. If the save store overflows or underflows, a sticky error flag is set and the mask keeps its value.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, `mask_o` is 7, `accept_o`, `ack_o` and `err_o` are 0, and the save store is empty.
- R2: A request is accepted when `req_valid` is 1, `reti` is 0, `req_level >= mask_o` and the store holds fewer than DEPTH entries. `accept_o` is then 1 for exactly the cycle after the one in which the request was presented. It is 0 in every other case.
- R3: When a request below level 7 is accepted, `mask_o` becomes `req_level + 1` in the same cycle in which `accept_o` is high.
- R4: On acceptance, the mask value in force before it is saved. A `reti` with a non-empty store sets `mask_o` on the next cycle to the most recently saved value.
- R5: Saved values come back in last-in-first-out order across several nested acceptances.
- R6: A level-7 request is accepted at any mask value, including 7, and the mask after it is 7.
- R7: `ack_o` is high for one cycle, exactly in the cycle after each `accept_o` pulse.
- R8: `mask_wr` loads `mask_wdata` into `mask_o` on the next cycle, unless `reti` is high or a request qualifies by level in the same cycle. In those cases the write is ignored.
- R9: A request that qualifies by level while DEPTH (default 8) values are saved is not accepted. It sets `err_o`, and `mask_o` does not change.
- R10: A `reti` while the store is empty sets `err_o` and leaves `mask_o` unchanged.
- R11: Once set, `err_o` stays 1 until reset.
- R12: When `reti` and a request arrive in the same cycle, only the return takes effect, and no accept is produced for that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | The arbiter is offering a request |
| req_level | input | 3 | Priority level of the offered request (7 = non-maskable) |
| reti | input | 1 | One-cycle return-from-interrupt strobe |
| mask_wr | input | 1 | Software mask load strobe |
| mask_wdata | input | 3 | Value for a software mask load |
| mask_o | output | 3 | Current mask level |
| accept_o | output | 1 | Request accepted (one-cycle pulse) |
| ack_o | output | 1 | Vector-fetch acknowledge to the arbiter (one-cycle pulse) |
| err_o | output | 1 | Sticky save-store overflow/underflow flag |

## Verification
Stimulus is applied at the falling edge. It is decided at the next rising edge, and `mask_o`, `accept_o` and `err_o` show the result one time unit after that edge, one cycle after the stimulus. `ack_o` comes one cycle later again. The bench therefore compares it against the accept value that its model predicted for the step before. The reference model advances its own mask, save store and error flag exactly once per edge. Every comparison is made after the edge, against the state the model expects for that cycle.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  parameter int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = '1;
endpackage

// File: rtl/irqm_level_cmp.sv
// Qualifies an offered request against the current mask and computes the
// raised mask that acceptance would install.
module irqm_level_cmp
  import irqm_pkg::*;
(
  input  logic req_valid,
  input  lvl_t req_level,
  input  lvl_t cur_mask,
  output logic hit,
  output lvl_t raised
);
  logic is_top;

  always_comb begin
    is_top = (req_level == LVL_TOP);
    hit    = req_valid && (is_top || (req_level >= cur_mask));
    raised = is_top ? LVL_TOP : lvl_t'(req_level + 1'b1);
  end
endmodule

// File: rtl/irqm_save_stack.sv
// Last-in-first-out store for mask values that are saved on acceptance.
module irqm_save_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     mem_q [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;

  always_comb begin
    full   = (cnt_q == CNT_W'(DEPTH));
    empty  = (cnt_q == '0);
    wr_idx = IDX_W'(cnt_q);
    rd_idx = IDX_W'(cnt_q - 1'b1);
    top    = mem_q[rd_idx];
    cnt_d  = cnt_q;
    if (push && !full)
      cnt_d = cnt_q + 1'b1;
    else if (pop && !empty)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wen;
    assign wen = push && !full && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wen)
        mem_q[g] <= din;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Top: mask register, accept/acknowledge pulses, nesting store, error flag.
module irq_mask_ctrl
  import irqm_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_level,
  input  logic       reti,
  input  logic       mask_wr,
  input  logic [2:0] mask_wdata,
  output logic [2:0] mask_o,
  output logic       accept_o,
  output logic       ack_o,
  output logic       err_o
);
  lvl_t mask_q, mask_d;
  logic accept_q, accept_d;
  logic ack_q, ack_d;
  logic err_q, err_d;

  logic cmp_hit;
  lvl_t cmp_raised;
  logic stk_full, stk_empty;
  lvl_t stk_top;
  logic do_push, do_pop, do_load, ovf, unf;

  irqm_level_cmp u_cmp (
    .req_valid (req_valid),
    .req_level (req_level),
    .cur_mask  (mask_q),
    .hit       (cmp_hit),
    .raised    (cmp_raised)
  );

  irqm_save_stack #(.DEPTH(DEPTH), .W(LVL_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (do_push),
    .pop   (do_pop),
    .din   (mask_q),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  // Priority: return > request > software load.
  always_comb begin
    do_pop   = reti && !stk_empty;
    unf      = reti && stk_empty;
    do_push  = !reti && cmp_hit && !stk_full;
    ovf      = !reti && cmp_hit && stk_full;
    do_load  = mask_wr && !reti && !cmp_hit;

    mask_d = mask_q;
    if (do_pop)
      mask_d = stk_top;
    else if (do_push)
      mask_d = cmp_raised;
    else if (do_load)
      mask_d = mask_wdata;

    accept_d = do_push;
    ack_d    = accept_q;
    err_d    = err_q || ovf || unf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= LVL_TOP;
      accept_q <= 1'b0;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      accept_q <= accept_d;
      ack_q    <= ack_d;
      err_q    <= err_d;
    end
  end

  assign mask_o   = mask_q;
  assign accept_o = accept_q;
  assign ack_o    = ack_q;
  assign err_o    = err_q;
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_level,
  input logic       reti,
  input logic [2:0] mask_o,
  input logic       accept_o,
  input logic       ack_o,
  input logic       err_o,
  input logic       stk_full,
  input logic       stk_empty
);
  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> ($past(req_valid) && !$past(reti) && ($past(req_level) >= $past(mask_o)))); // R2
  AST_LOW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_level < mask_o)) |=> !accept_o); // R2
  AST_MASK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && ($past(req_level) != 3'd7)) |-> (mask_o == 3'($past(req_level) + 3'd1))); // R3
  AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && ($past(req_level) == 3'd7)) |-> (mask_o == 3'd7)); // R6
  AST_ACK_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> ack_o); // R7
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !reti && (req_level == 3'd7) && stk_full) |=> (!accept_o && err_o && $stable(mask_o))); // R9
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && stk_empty) |=> (err_o && $stable(mask_o))); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R11
  AST_RETI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && req_valid) |=> !accept_o); // R12
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_level (req_level),
  .reti      (reti),
  .mask_o    (mask_o),
  .accept_o  (accept_o),
  .ack_o     (ack_o),
  .err_o     (err_o),
  .stk_full  (stk_full),
  .stk_empty (stk_empty)
);

// File: tb/sim_irq_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctrl;
  localparam int DEPTH = 8;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_level;
  logic       reti;
  logic       mask_wr;
  logic [2:0] mask_wdata;
  logic [2:0] mask_o;
  logic       accept_o;
  logic       ack_o;
  logic       err_o;

  int n_chk;
  int n_bad;

  // reference model state
  logic [2:0] m_mask;
  logic [2:0] m_stk [DEPTH];
  int         m_cnt;
  logic       m_err;
  logic       m_acc;

  irq_mask_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .reti(reti), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .mask_o(mask_o), .accept_o(accept_o), .ack_o(ack_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic f_qualifies(logic v, logic [2:0] lvl, logic [2:0] msk);
    return v && ((lvl == 3'd7) || (lvl >= msk));
  endfunction

  function automatic logic [2:0] f_raised(logic [2:0] lvl);
    return (lvl == 3'd7) ? 3'd7 : 3'(lvl + 3'd1);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; req_level = '0; reti = 1'b0;
    mask_wr = 1'b0; mask_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mask = 3'd7; m_cnt = 0; m_err = 1'b0; m_acc = 1'b0;
    #1;
    check("R1 mask", mask_o, 7);
    check("R1 accept", accept_o, 0);
    check("R1 ack", ack_o, 0);
    check("R1 err", err_o, 0);
  endtask

  // One cycle: drive at negedge, update model, sample after the rising edge.
  task automatic step(logic v, logic [2:0] lvl, logic rt, logic wr, logic [2:0] wd);
    logic       hit, acc_now;
    logic [2:0] exp_mask;
    string      tag;
    @(negedge clk);
    req_valid = v; req_level = lvl; reti = rt; mask_wr = wr; mask_wdata = wd;
    hit = f_qualifies(v, lvl, m_mask);
    acc_now = 1'b0;
    exp_mask = m_mask;
    tag = "R2";
    if (rt) begin
      if (m_cnt == 0) begin
        m_err = 1'b1; tag = "R10";
      end else begin
        tag = (m_cnt > 1) ? "R5" : "R4";
        m_cnt--;
        exp_mask = m_stk[m_cnt];
      end
      if (v) tag = {tag, "/R12"};
    end else if (hit) begin
      if (m_cnt == DEPTH) begin
        m_err = 1'b1; tag = "R9";
      end else begin
        m_stk[m_cnt] = m_mask;
        m_cnt++;
        exp_mask = f_raised(lvl);
        acc_now = 1'b1;
        tag = (lvl == 3'd7) ? "R6" : "R3";
      end
    end else if (wr) begin
      exp_mask = wd;
      tag = "R8";
    end
    @(posedge clk);
    #1;
    check({tag, " mask"}, mask_o, exp_mask);
    check({tag, " accept"}, accept_o, acc_now);
    check("R7 ack", ack_o, m_acc);
    check("R11 err", err_o, m_err);
    m_mask = exp_mask;
    m_acc  = acc_now;
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_level = '0; reti = 1'b0; mask_wr = 1'b0; mask_wdata = '0;
    void'($urandom(32'd20240611));

    do_reset();
    // R1/R2: maskable request is blocked at reset mask of 7
    step(1, 3'd6, 0, 0, 3'd0);
    // R8: software lowers the mask
    step(0, 3'd0, 0, 1, 3'd1);
    // R3/R4/R5: nest 1 -> 3 -> 5 -> 7
    step(1, 3'd1, 0, 0, 3'd0);
    step(1, 3'd1, 0, 0, 3'd0);   // R2: below raised mask 2
    step(1, 3'd3, 0, 0, 3'd0);
    step(1, 3'd5, 0, 0, 3'd0);
    step(1, 3'd7, 0, 0, 3'd0);   // R6
    step(1, 3'd7, 0, 0, 3'd0);   // R6 at mask 7
    // R12: return and request together
    step(1, 3'd7, 1, 0, 3'd0);
    // R8 ignored when a request qualifies
    step(1, 3'd7, 0, 1, 3'd2);
    // R8 ignored during return
    step(0, 3'd0, 1, 1, 3'd3);
    repeat (4) step(0, 3'd0, 1, 0, 3'd0);
    // R10: underflow then R11 sticky
    step(0, 3'd0, 1, 0, 3'd0);
    step(0, 3'd0, 0, 1, 3'd0);
    step(1, 3'd0, 0, 0, 3'd0);

    // R9: overflow
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 3'd7, 0, 0, 3'd0);
    step(1, 3'd7, 0, 0, 3'd0);
    step(0, 3'd0, 1, 0, 3'd0);

    // constrained random segments
    for (int seg = 0; seg < 6; seg++) begin
      do_reset();
      step(0, 3'd0, 0, 1, 3'($urandom_range(0, 3)));
      for (int k = 0; k < 500; k++) begin
        logic v, rt, wr;
        v  = ($urandom_range(0, 99) < 50);
        rt = ($urandom_range(0, 99) < 18);
        wr = ($urandom_range(0, 99) < 10);
        step(v, 3'($urandom_range(0, 7)), rt, wr, 3'($urandom_range(0, 7)));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule